// File: doc/BRIEF.md
# Dual-Address DMA Channel Engine

A single DMA channel that copies a block of bytes from a source region to a destination region. Each operand moves in two steps. The engine reads the whole operand from the source into a 16-bit holding register, then writes that register to the destination. The source and the destination each choose their own operand size, byte or 16-bit word. When the sizes differ, one side of an operand takes two byte bus cycles and the other side takes one word cycle.

The host programs the pointers, byte count, function codes and control bits through a small register port, then sets the start bit. The engine runs bus cycles as a master on an asynchronous-style port. It holds the strobe until the acknowledge arrives, then releases it for at least one cycle. When the count reaches zero, the engine sets a done flag and raises an interrupt if interrupts are enabled. In external-request mode, each operand waits for the request input.

Top module: `dma_chan_engine`

## Requirements
- R1: Register map by `host_addr`:
  - 0: control. Bit0 start, bit1 source increment, bit2 destination increment, bit3 source word size, bit4 destination word size, bit5 interrupt enable, bit6 external-request mode.
  - 1: status. Bit0 busy, bit1 done, bit2 configuration error. Bits 1 and 2 are cleared by writing 1.
  - 2: source pointer. 3: destination pointer. 4: byte count.
  - 5: function codes. Source in [2:0], destination in [6:4].
  - After reset every register reads zero and `bus_strobe` and `irq` are low.
- R2: Every operand is read completely before it is written.
  - A read cycle drives the source pointer and source function code with `bus_rnw`=1.
  - A write cycle drives the destination pointer and destination function code with `bus_rnw`=0.
  - `bus_word`=1 marks a word cycle, and word cycles only use even addresses.
- R3: The strobe and all cycle attributes stay stable until `bus_ack` is seen with the strobe high. The strobe is then low for at least one cycle. Read data is captured on the acknowledged edge.
- R4: An operand is a word if either side is word-sized and at least 2 bytes remain; otherwise it is one byte. A word operand needs 1 cycle on a word side and 2 byte cycles on a byte side. A single-byte operand uses one byte cycle on each side.
- R5: Byte data travels on bits [7:0]. Word data is big-endian: the byte at the lower address is bits [15:8]. When two byte reads build a word, the first byte goes to the upper half. When a word is split into two byte writes, the upper half is written first.
- R6: A pointer with increment enabled advances by the operand size once its side of the operand completes. With increment disabled, the pointer never changes and both byte cycles of a split use the same address.
- R7: The byte count decreases by the operand size after each completed destination write.
- R8: When the count is zero, the channel clears busy and the start bit and sets done. `irq` equals done AND interrupt enable. Writing 1 to status bit1 clears done and drops `irq`.
- R9: Setting start is refused when a side with increment disabled has an odd pointer. The refusal sets status bit2, runs no bus cycles and leaves the channel idle.
- R10: In internal mode, operands follow each other without waiting. In external-request mode, no operand begins until `xfer_req` is seen high; each high cycle releases one operand.
- R11: Writing control with start=0 during a block stops the channel at the end of the next acknowledged bus cycle. Busy clears, done stays 0, no further bus cycles run, and the pointers and count keep their values at that point.
- R12: Host writes to the pointers, count or function codes while busy are ignored.
- R13: Starting with a count of zero sets done at once, with no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write enable |
| host_addr | input | 3 | Register select |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data (combinational) |
| xfer_req | input | 1 | Operand request in external-request mode |
| bus_strobe | output | 1 | Bus cycle in progress |
| bus_rnw | output | 1 | 1 = read, 0 = write |
| bus_word | output | 1 | 1 = word cycle, 0 = byte cycle |
| bus_addr | output | ADDR_W | Bus address |
| bus_fc | output | FC_W | Bus function code |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_ack | input | 1 | Cycle acknowledge |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest case to reach is a stop that lands in the middle of a block. The source pointer may already have advanced for an operand whose write never happened. To get there, the bench slows each cycle with acknowledge wait states and clears start after a fixed delay. It then checks that the destination pointer and the count agree exactly, and that the source pointer is at most one operand ahead. Byte-order faults are exposed with a fixed-address source port that returns a rising sequence, and with a fixed-address destination port that logs the order of its writes.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_RD   = 2'd2,
        S_WR   = 2'd3
    } dmac_state_e;

    // bit0 = start ... bit6 = external request mode
    typedef struct packed {
        logic ext_mode;
        logic irq_en;
        logic dst_word;
        logic src_word;
        logic dst_inc;
        logic src_inc;
        logic go;
    } dmac_ctrl_t;

    localparam int CTRL_W = $bits(dmac_ctrl_t);

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_STAT = 3'd1;
    localparam logic [2:0] RA_SRC  = 3'd2;
    localparam logic [2:0] RA_DST  = 3'd3;
    localparam logic [2:0] RA_CNT  = 3'd4;
    localparam logic [2:0] RA_FC   = 3'd5;

    function automatic logic [1:0] op_bytes(input logic is_word);
        return is_word ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int FC_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [2:0]        host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic              busy_i,
    input  logic              adv_src,
    input  logic              adv_dst,
    input  logic              step_two,
    input  logic              done_set,
    output dmac_ctrl_t        ctl,
    output logic [ADDR_W-1:0] src_ptr,
    output logic [ADDR_W-1:0] dst_ptr,
    output logic [CNT_W-1:0]  count,
    output logic [FC_W-1:0]   src_fc,
    output logic [FC_W-1:0]   dst_fc,
    output logic              irq
);
    localparam int DST_FC_LSB = 4;

    dmac_ctrl_t ctl_q, ctl_w;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [FC_W-1:0]   sfc_q, dfc_q;
    logic done_q, err_q;
    logic wr_ctl, wr_stat, bad_cfg, try_go, idle_wr;
    logic [ADDR_W-1:0] ptr_step;
    logic [CNT_W-1:0]  cnt_step;

    assign ctl_w    = dmac_ctrl_t'(host_wdata[CTRL_W-1:0]);
    assign wr_ctl   = host_we && (host_addr == RA_CTRL);
    assign wr_stat  = host_we && (host_addr == RA_STAT);
    assign idle_wr  = host_we && !busy_i;
    assign bad_cfg  = (!ctl_w.src_inc && src_q[0]) || (!ctl_w.dst_inc && dst_q[0]);
    assign try_go   = wr_ctl && ctl_w.go && !busy_i;
    assign ptr_step = ADDR_W'(op_bytes(step_two));
    assign cnt_step = CNT_W'(op_bytes(step_two));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            sfc_q  <= '0;
            dfc_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (wr_ctl && !busy_i) begin
                ctl_q    <= ctl_w;
                ctl_q.go <= ctl_w.go && !bad_cfg;
            end else if (wr_ctl && !ctl_w.go) begin
                ctl_q.go <= 1'b0;
            end
            if (done_set) ctl_q.go <= 1'b0;

            if (idle_wr && host_addr == RA_SRC) src_q <= host_wdata[ADDR_W-1:0];
            else if (adv_src && ctl_q.src_inc)  src_q <= src_q + ptr_step;

            if (idle_wr && host_addr == RA_DST) dst_q <= host_wdata[ADDR_W-1:0];
            else if (adv_dst && ctl_q.dst_inc)  dst_q <= dst_q + ptr_step;

            if (idle_wr && host_addr == RA_CNT) cnt_q <= host_wdata[CNT_W-1:0];
            else if (adv_dst)                   cnt_q <= cnt_q - cnt_step;

            if (idle_wr && host_addr == RA_FC) begin
                sfc_q <= host_wdata[FC_W-1:0];
                dfc_q <= host_wdata[DST_FC_LSB +: FC_W];
            end

            if (done_set)                     done_q <= 1'b1;
            else if (wr_stat && host_wdata[1]) done_q <= 1'b0;

            if (try_go && bad_cfg)             err_q <= 1'b1;
            else if (wr_stat && host_wdata[2]) err_q <= 1'b0;
        end
    end

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            RA_CTRL: host_rdata = 32'(ctl_q);
            RA_STAT: host_rdata = {29'd0, err_q, done_q, busy_i};
            RA_SRC:  host_rdata = 32'(src_q);
            RA_DST:  host_rdata = 32'(dst_q);
            RA_CNT:  host_rdata = 32'(cnt_q);
            RA_FC:   host_rdata = 32'(dfc_q) << DST_FC_LSB | 32'(sfc_q);
            default: host_rdata = '0;
        endcase
    end

    assign ctl     = ctl_q;
    assign src_ptr = src_q;
    assign dst_ptr = dst_q;
    assign count   = cnt_q;
    assign src_fc  = sfc_q;
    assign dst_fc  = dfc_q;
    assign irq     = done_q && ctl_q.irq_en;

    // R8: done only rises once the count has run out
    assert_done_zero_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> cnt_q == '0);
    // R9: a refused start leaves the channel idle
    assert_cfg_reject_R9: assert property (@(posedge clk) disable iff (rst)
        (try_go && bad_cfg) |=> !ctl_q.go);
    // R12: pointer only moves through the engine while busy
    assert_src_frozen_R12: assert property (@(posedge clk) disable iff (rst)
        (busy_i && !adv_src) |=> $stable(src_q));
endmodule

// File: rtl/dmac_hold.sv
module dmac_hold (
    input  logic        clk,
    input  logic        rst,
    input  logic        cap,
    input  logic        cyc_word,
    input  logic        split,
    input  logic        half,
    input  logic [15:0] rdata,
    output logic [15:0] wr_lane
);
    logic [15:0] hold_q;
    logic        upper_sel;

    assign upper_sel = split && !half;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (cap) begin
            if (cyc_word)       hold_q        <= rdata;
            else if (upper_sel) hold_q[15:8]  <= rdata[7:0];
            else                hold_q[7:0]   <= rdata[7:0];
        end
    end

    assign wr_lane = cyc_word ? hold_q
                              : {8'h00, upper_sel ? hold_q[15:8] : hold_q[7:0]};
endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int FC_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  dmac_ctrl_t        ctl,
    input  logic [ADDR_W-1:0] src_ptr,
    input  logic [ADDR_W-1:0] dst_ptr,
    input  logic [CNT_W-1:0]  count,
    input  logic [FC_W-1:0]   src_fc,
    input  logic [FC_W-1:0]   dst_fc,
    input  logic              xfer_req,
    input  logic              bus_ack,
    output logic              bus_strobe,
    output logic              bus_rnw,
    output logic              bus_word,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [FC_W-1:0]   bus_fc,
    output logic              hold_cap,
    output logic              split,
    output logic              half_o,
    output logic              busy,
    output logic              adv_src,
    output logic              adv_dst,
    output logic              step_two,
    output logic              done_set
);
    dmac_state_e st_q;
    logic half_q, gap_q, opw_q;
    logic in_rd, in_cyc, side_word, side_inc, acked, last_cyc;
    logic cnt_zero, cnt_one, may_go;

    assign in_rd     = (st_q == S_RD);
    assign in_cyc    = (st_q == S_RD) || (st_q == S_WR);
    assign side_word = in_rd ? ctl.src_word : ctl.dst_word;
    assign side_inc  = in_rd ? ctl.src_inc  : ctl.dst_inc;
    assign split     = opw_q && !side_word;
    assign bus_word  = opw_q && side_word;
    assign bus_strobe = in_cyc && !gap_q;
    assign acked     = bus_strobe && bus_ack;
    assign last_cyc  = !split || half_q;
    assign cnt_zero  = (count == '0);
    assign cnt_one   = (count == CNT_W'(1));
    assign may_go    = !ctl.ext_mode || xfer_req;

    assign bus_rnw  = in_rd;
    assign bus_fc   = in_rd ? src_fc : dst_fc;
    assign bus_addr = (in_rd ? src_ptr : dst_ptr) + ADDR_W'(side_inc && half_q);
    assign hold_cap = in_rd && acked;
    assign half_o   = half_q;
    assign step_two = opw_q;
    assign adv_src  = in_rd && acked && last_cyc;
    assign adv_dst  = (st_q == S_WR) && acked && last_cyc;
    assign done_set = (st_q == S_WAIT) && ctl.go && cnt_zero;
    assign busy     = (st_q != S_IDLE) || ctl.go;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            half_q <= 1'b0;
            gap_q  <= 1'b0;
            opw_q  <= 1'b0;
        end else begin
            gap_q <= acked;
            case (st_q)
                S_IDLE: if (ctl.go) st_q <= S_WAIT;
                S_WAIT: begin
                    if (!ctl.go || cnt_zero) begin
                        st_q <= S_IDLE;
                    end else if (may_go) begin
                        opw_q  <= (ctl.src_word || ctl.dst_word) && !cnt_one;
                        half_q <= 1'b0;
                        st_q   <= S_RD;
                    end
                end
                S_RD, S_WR: begin
                    if (acked) begin
                        if (last_cyc) begin
                            half_q <= 1'b0;
                            if (!ctl.go)   st_q <= S_IDLE;
                            else if (in_rd) st_q <= S_WR;
                            else           st_q <= S_WAIT;
                        end else begin
                            half_q <= 1'b1;
                        end
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // R3: strobe released for a cycle after every acknowledge
    assert_strobe_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && bus_ack) |=> !bus_strobe);
    // R3: cycle attributes held until acknowledged
    assert_cycle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && !bus_ack) |=> bus_strobe && $stable(bus_addr)
                                     && $stable(bus_rnw) && $stable(bus_word));
    // R10: no cycle starts while an external request is missing
    assert_ext_wait_R10: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_WAIT && ctl.go && !cnt_zero && ctl.ext_mode && !xfer_req)
        |=> !bus_strobe);
    // R2: word cycles only at even addresses
    assert_word_even_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && bus_word && side_inc) |-> !bus_addr[0]);
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int FC_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [2:0]        host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic              xfer_req,
    output logic              bus_strobe,
    output logic              bus_rnw,
    output logic              bus_word,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [FC_W-1:0]   bus_fc,
    output logic [15:0]       bus_wdata,
    input  logic [15:0]       bus_rdata,
    input  logic              bus_ack,
    output logic              irq
);
    dmac_ctrl_t        ctl;
    logic [ADDR_W-1:0] src_ptr, dst_ptr;
    logic [CNT_W-1:0]  count;
    logic [FC_W-1:0]   src_fc, dst_fc;
    logic busy, adv_src, adv_dst, step_two, done_set;
    logic hold_cap, split, half;

    dmac_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .FC_W(FC_W)) u_regs (
        .clk(clk), .rst(rst),
        .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .busy_i(busy), .adv_src(adv_src), .adv_dst(adv_dst),
        .step_two(step_two), .done_set(done_set),
        .ctl(ctl), .src_ptr(src_ptr), .dst_ptr(dst_ptr), .count(count),
        .src_fc(src_fc), .dst_fc(dst_fc), .irq(irq)
    );

    dmac_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .FC_W(FC_W)) u_ctrl (
        .clk(clk), .rst(rst), .ctl(ctl),
        .src_ptr(src_ptr), .dst_ptr(dst_ptr), .count(count),
        .src_fc(src_fc), .dst_fc(dst_fc),
        .xfer_req(xfer_req), .bus_ack(bus_ack),
        .bus_strobe(bus_strobe), .bus_rnw(bus_rnw), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_fc(bus_fc),
        .hold_cap(hold_cap), .split(split), .half_o(half),
        .busy(busy), .adv_src(adv_src), .adv_dst(adv_dst),
        .step_two(step_two), .done_set(done_set)
    );

    dmac_hold u_hold (
        .clk(clk), .rst(rst), .cap(hold_cap),
        .cyc_word(bus_word), .split(split), .half(half),
        .rdata(bus_rdata), .wr_lane(bus_wdata)
    );
endmodule

// File: tb/sim_dma_chan_engine.sv
module sim_dma_chan_engine;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] C_GO = 1, C_SI = 2, C_DI = 4, C_SW = 8,
                            C_DW = 16, C_IE = 32, C_EX = 64;

    typedef struct packed {
        logic       sw;
        logic       dw;
        logic [7:0] cnt;
        logic [7:0] cyc;
        logic [1:0] wt;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{sw:1'b0, dw:1'b0, cnt:8'd5, cyc:8'd10, wt:2'd0},
        '{sw:1'b1, dw:1'b1, cnt:8'd6, cyc:8'd6,  wt:2'd1},
        '{sw:1'b0, dw:1'b1, cnt:8'd4, cyc:8'd6,  wt:2'd2},
        '{sw:1'b1, dw:1'b0, cnt:8'd5, cyc:8'd8,  wt:2'd3},
        '{sw:1'b1, dw:1'b1, cnt:8'd3, cyc:8'd4,  wt:2'd0},
        '{sw:1'b0, dw:1'b1, cnt:8'd1, cyc:8'd2,  wt:2'd1}
    };

    logic clk = 0, rst = 1;
    logic host_we = 0, xfer_req = 0, bus_ack = 0;
    logic [2:0] host_addr = 0;
    logic [31:0] host_wdata = 0, host_rdata;
    logic bus_strobe, bus_rnw, bus_word, irq;
    logic [23:0] bus_addr;
    logic [2:0] bus_fc;
    logic [15:0] bus_wdata, bus_rdata = 0;

    int n_chk = 0, n_bad = 0;
    int cyc_n = 0, fc_bad = 0, wait_n = 0, plog_n = 0;
    logic [7:0] mem [256];
    logic [7:0] plog [4];
    logic [7:0] port_val = 8'h11;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_engine u0 (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .xfer_req(xfer_req),
        .bus_strobe(bus_strobe), .bus_rnw(bus_rnw), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .irq(irq)
    );

    function automatic logic [7:0] minit(input int i);
        return 8'(i * 7 + 3);
    endfunction

    task automatic fill_mem();
        for (int i = 0; i < 256; i++) mem[i] = minit(i);
    endtask

    // bus slave: big-endian word memory, byte port at F0 (read) and F2 (write log)
    initial begin
        int wc;
        wc = 0;
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 0;
            end else if (bus_strobe) begin
                if (wc < wait_n) begin
                    wc++;
                end else begin
                    logic [7:0] a;
                    wc = 0;
                    a = bus_addr[7:0];
                    cyc_n++;
                    if (bus_fc != (bus_rnw ? 3'd5 : 3'd2)) fc_bad++;
                    if (bus_word && a[0]) fc_bad++;
                    if (bus_rnw) begin
                        if (bus_word)        bus_rdata = {mem[a], mem[a | 8'd1]};
                        else if (a == 8'hF0) begin bus_rdata = {8'h00, port_val}; port_val++; end
                        else                 bus_rdata = {8'h00, mem[a]};
                    end else begin
                        if (bus_word) begin
                            mem[a] = bus_wdata[15:8];
                            mem[a | 8'd1] = bus_wdata[7:0];
                        end else if (a == 8'hF2) begin
                            if (plog_n < 4) plog[plog_n] = bus_wdata[7:0];
                            plog_n++;
                        end else begin
                            mem[a] = bus_wdata[7:0];
                        end
                    end
                    bus_ack = 1;
                end
            end
        end
    end

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 0;
    endtask

    task automatic hr(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] s;
        int k;
        repeat (3) @(posedge clk);
        k = 0;
        hr(3'd1, s);
        while (s[0] && k < 5000) begin hr(3'd1, s); k++; end
        check_eq({req, " completes"}, 32'(k < 5000), 32'd1);
    endtask

    task automatic setup(input logic [7:0] s, input logic [7:0] d, input logic [7:0] c);
        hw(3'd1, 32'h6);
        hw(3'd2, 32'(s));
        hw(3'd3, 32'(d));
        hw(3'd4, 32'(c));
        hw(3'd5, 32'h25);
        cyc_n = 0; fc_bad = 0; plog_n = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r, c0, s0, d0;
        int snap, mis;
        fill_mem();
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            hr(3'(a), r);
            check_eq("R1 reg reset", r, 0);
        end
        check_eq("R1 strobe low", 32'(bus_strobe), 0);
        check_eq("R1 irq low", 32'(irq), 0);

        // vector table: sizes, odd counts, wait states
        foreach (VECS[i]) begin
            vec_t v;
            v = VECS[i];
            wait_n = int'(v.wt);
            fill_mem();
            setup(8'h10, 8'h80, v.cnt);
            hw(3'd0, C_GO | C_SI | C_DI | C_IE | (v.sw ? C_SW : 0) | (v.dw ? C_DW : 0));
            wait_idle("R8");
            hr(3'd4, r); check_eq("R7 count zero", r, 0);
            hr(3'd2, r); check_eq("R6 src advanced", r, 32'h10 + 32'(v.cnt));
            hr(3'd3, r); check_eq("R6 dst advanced", r, 32'h80 + 32'(v.cnt));
            hr(3'd1, r); check_eq("R8 status done", r, 32'h2);
            hr(3'd0, r); check_eq("R8 start cleared", r & 1, 0);
            check_eq("R8 irq raised", 32'(irq), 1);
            check_eq("R4 bus cycle count", 32'(cyc_n), 32'(v.cyc));
            check_eq("R2 fc/attrs", 32'(fc_bad), 0);
            mis = 0;
            for (int b = 0; b < int'(v.cnt); b++)
                if (mem[8'h80 + b] !== minit(16 + b)) mis++;
            check_eq("R5 data copied", 32'(mis), 0);
            check_eq("R2 no overrun", 32'(mem[8'h80 + v.cnt]), 32'(minit(128 + int'(v.cnt))));
            hw(3'd1, 32'h2);
            check_eq("R8 irq cleared", 32'(irq), 0);
        end

        // R5/R6: byte port (no increment) packed into words
        wait_n = 0; fill_mem(); port_val = 8'h11;
        setup(8'hF0, 8'hA0, 8'd4);
        hw(3'd0, C_GO | C_DI | C_DW);
        wait_idle("R5");
        check_eq("R5 packed upper first", {mem[8'hA0], mem[8'hA1], mem[8'hA2], mem[8'hA3]}, 32'h11121314);
        hr(3'd2, r); check_eq("R6 fixed src ptr", r, 32'hF0);
        check_eq("R8 irq disabled", 32'(irq), 0);

        // R5: word split to byte port, upper half first
        fill_mem();
        setup(8'h20, 8'hF2, 8'd2);
        hw(3'd0, C_GO | C_SI | C_SW);
        wait_idle("R5");
        check_eq("R5 split count", 32'(plog_n), 2);
        check_eq("R5 split order", {plog[0], plog[1]}, {minit(32), minit(33)});
        hr(3'd3, r); check_eq("R6 fixed dst ptr", r, 32'hF2);

        // R9: odd pointer without increment
        setup(8'h41, 8'h80, 8'd4);
        hw(3'd0, C_GO | C_DI);
        repeat (10) @(posedge clk);
        hr(3'd1, r); check_eq("R9 config error", r, 32'h4);
        check_eq("R9 no cycles", 32'(cyc_n), 0);
        hw(3'd1, 32'h4);
        hr(3'd1, r); check_eq("R9 error cleared", r, 0);

        // R13: zero count
        setup(8'h10, 8'h80, 8'd0);
        hw(3'd0, C_GO | C_SI | C_DI);
        wait_idle("R13");
        hr(3'd1, r); check_eq("R13 done at once", r, 32'h2);
        check_eq("R13 no cycles", 32'(cyc_n), 0);

        // R10: external request mode
        setup(8'h10, 8'h80, 8'd2);
        hw(3'd0, C_GO | C_SI | C_DI | C_EX);
        repeat (20) @(posedge clk);
        check_eq("R10 waits for request", 32'(cyc_n), 0);
        hr(3'd1, r); check_eq("R10 busy while waiting", r & 1, 1);
        @(negedge clk) xfer_req = 1;
        @(negedge clk) xfer_req = 0;
        repeat (20) @(posedge clk);
        check_eq("R10 one operand", 32'(cyc_n), 2);
        hr(3'd4, r); check_eq("R10 count after one", r, 1);
        @(negedge clk) xfer_req = 1;
        @(negedge clk) xfer_req = 0;
        wait_idle("R10");
        hr(3'd1, r); check_eq("R10 done", r, 32'h2);

        // R12: writes while busy ignored
        wait_n = 2;
        setup(8'h10, 8'h80, 8'd6);
        hw(3'd0, C_GO | C_SI | C_DI);
        hw(3'd2, 32'h0);
        hw(3'd4, 32'd100);
        wait_idle("R12");
        hr(3'd2, r); check_eq("R12 src write ignored", r, 32'h16);
        hr(3'd4, r); check_eq("R12 count write ignored", r, 0);

        // R11: stop in mid-block
        wait_n = 3;
        setup(8'h10, 8'h80, 8'd20);
        hw(3'd0, C_GO | C_SI | C_DI | C_IE);
        repeat (40) @(posedge clk);
        hw(3'd0, C_SI | C_DI | C_IE);
        wait_idle("R11");
        hr(3'd4, c0); hr(3'd2, s0); hr(3'd3, d0); hr(3'd1, r);
        check_eq("R11 no done", r, 0);
        check_eq("R11 partial count", 32'(c0 != 0 && c0 != 20), 1);
        check_eq("R11 dst matches count", d0, 32'h80 + 32'd20 - c0);
        check_eq("R11 src within one", 32'(s0 == 32'h10 + 32'd20 - c0 || s0 == 32'h10 + 32'd21 - c0), 1);
        snap = cyc_n;
        repeat (40) @(posedge clk);
        check_eq("R11 bus quiet", 32'(cyc_n), 32'(snap));
        check_eq("R11 irq low", 32'(irq), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule